// File: doc/BRIEF.md
# Variable Block Size SAD Merger

This block sits behind a motion estimation engine that delivers, for each search position, the sum of absolute differences of the sixteen 4x4 sub-blocks of a 16x16 macroblock. From those sixteen values it builds the cost of every sub-partition shape of the macroblock. There are 41 shapes: 16 of 4x4, 8 of 4x8, 8 of 8x4, 4 of 8x8, 2 of 8x16, 2 of 16x8 and one 16x16. Two shared adder trees do the merging. A vertical tree pairs blocks on top of each other (4x8, then 8x8, 8x16 and 16x16). A horizontal tree pairs side-by-side blocks (8x4) and reuses the vertical tree's 8x8 sums to form 16x8.

Each of the 41 shapes has a slot that holds the lowest cost seen so far and the displacement that gave it. A start pulse opens a search over a 16x16 window of displacements, from -8 to +7 on each axis. Every accepted candidate then updates all 41 slots in the same cycle. After the 256th candidate the block pulses done, and all 41 cost and vector pairs are held on its outputs for the mode decision logic downstream.

Top module: `vbs_sad_merger`

## Requirements
- R1: During and after reset, every slot holds cost all ones and vector zero, and done is low.
- R2: In the cycle after start, every slot holds cost all ones and vector zero, and the candidate count is back at zero. A valid given in the same cycle as start is not counted and updates no slot.
- R3: The k-th accepted candidate after start (k from 0) has dx = (k mod 16) - 8 and dy = (k div 16) - 8. Each slot's vector field is 8 bits: dy in bits 7:4 and dx in bits 3:0, both 4-bit two's complement.
- R4: 4x4 sub-block (row r, column c) enters on sad4 bits [(4r+c)*12 +: 12], and slot 4r+c holds its cost. Slot 16+4p+c (4x8) is sub-blocks (2p,c) and (2p+1,c). Slot 24+2r+q (8x4) is sub-blocks (r,2q) and (r,2q+1).
- R5: Slot 32+2p+q (8x8) is sub-block rows 2p..2p+1 by columns 2q..2q+1. Slot 36+q (8x16) is all rows by columns 2q..2q+1. Slot 38+p (16x8) is rows 2p..2p+1 by all columns. Slot 40 is the whole macroblock.
- R6: A slot is overwritten only when the new candidate's cost is strictly lower, so on equal costs the earlier candidate is kept.
- R7: done is high for exactly one cycle, the cycle after the 256th accepted candidate. From then on, all slots hold the final minima until the next start.
- R8: After the search has ended and before a new start, valid has no effect on any slot.
- R9: Slot costs are 16 bits wide. With all sixteen inputs at 4095, slot 40 reads 65520 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new search and clears all slots |
| valid | input | 1 | sad4 carries one candidate's sixteen costs |
| sad4 | input | 192 | Sixteen 12-bit 4x4 costs, sub-block (r,c) at index 4r+c |
| done | output | 1 | One-cycle pulse after the last candidate |
| min_sad | output | 656 | 41 slot costs, 16 bits each, slot n at [n*16 +: 16] |
| min_mv | output | 328 | 41 slot vectors, 8 bits each, slot n at [n*8 +: 8] |

## Verification
The bench goes after the tie rule by feeding identical costs at every position. A design that used less-or-equal would report +7,+7 instead of -8,-8 in every slot. It sets all inputs to 4095 to catch a slot too narrow for the full macroblock sum, which would show a wrapped value. A descending cost sweep makes the last position win, which exposes a swapped or mis-offset dx/dy. Start arriving together with valid, and valid arriving after done, are both driven, so a counter that counts the wrong beat or slots that keep updating after the search show up as shifted vectors or changed minima.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
    localparam int SAD4_W_DEF = 12;
    localparam int SRANGE_DEF = 8;
    localparam int NUM_BLK    = 16;
    localparam int NUM_SLOT   = 41;
    // first slot of each shape group
    localparam int BASE_4X8   = 16;
    localparam int BASE_8X4   = 24;
    localparam int BASE_8X8   = 32;
    localparam int BASE_8X16  = 36;
    localparam int BASE_16X8  = 38;
    localparam int BASE_16X16 = 40;

    typedef enum logic {ST_IDLE, ST_RUN} srch_state_e;

    function automatic int blk_idx(input int row, input int col);
        return row * 4 + col;
    endfunction
endpackage

// File: rtl/vbs_vert_tree.sv
module vbs_vert_tree #(
    parameter int SAD_W = 16
) (
    input  logic [15:0][SAD_W-1:0] blk,
    output logic [7:0][SAD_W-1:0]  s4x8,
    output logic [3:0][SAD_W-1:0]  s8x8,
    output logic [1:0][SAD_W-1:0]  s8x16,
    output logic [SAD_W-1:0]       s16x16
);
    import vbs_pkg::*;
    for (genvar p = 0; p < 2; p++) begin : g_pair_row
        for (genvar c = 0; c < 4; c++) begin : g_col
            assign s4x8[p*4+c] = blk[blk_idx(2*p, c)] + blk[blk_idx(2*p+1, c)];
        end
        for (genvar q = 0; q < 2; q++) begin : g_quad
            assign s8x8[p*2+q] = s4x8[p*4+2*q] + s4x8[p*4+2*q+1];
        end
    end
    for (genvar q = 0; q < 2; q++) begin : g_tall
        assign s8x16[q] = s8x8[q] + s8x8[2+q];
    end
    assign s16x16 = s8x16[0] + s8x16[1];
endmodule

// File: rtl/vbs_horz_tree.sv
module vbs_horz_tree #(
    parameter int SAD_W = 16
) (
    input  logic [15:0][SAD_W-1:0] blk,
    input  logic [3:0][SAD_W-1:0]  s8x8,
    output logic [7:0][SAD_W-1:0]  s8x4,
    output logic [1:0][SAD_W-1:0]  s16x8
);
    import vbs_pkg::*;
    for (genvar r = 0; r < 4; r++) begin : g_row
        for (genvar q = 0; q < 2; q++) begin : g_half
            assign s8x4[r*2+q] = blk[blk_idx(r, 2*q)] + blk[blk_idx(r, 2*q+1)];
        end
    end
    for (genvar p = 0; p < 2; p++) begin : g_wide
        assign s16x8[p] = s8x8[p*2] + s8x8[p*2+1];
    end
endmodule

// File: rtl/vbs_cand_ctr.sv
module vbs_cand_ctr
    import vbs_pkg::*;
#(
    parameter int SEARCH_R = 8,
    parameter int MVC_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               valid,
    output logic               accept,
    output logic               busy,
    output logic               done,
    output logic [2*MVC_W-1:0] cand_mv
);
    localparam logic [MVC_W-1:0] OFS = MVC_W'(SEARCH_R);

    srch_state_e        state;
    logic [2*MVC_W-1:0] idx;
    logic [MVC_W-1:0]   dx, dy;

    assign busy    = (state == ST_RUN);
    assign accept  = valid && busy && !start;
    assign dx      = idx[MVC_W-1:0] - OFS;
    assign dy      = idx[2*MVC_W-1:MVC_W] - OFS;
    assign cand_mv = {dy, dx};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state <= ST_RUN;
                idx   <= '0;
            end else if (accept) begin
                idx <= idx + 1'b1;
                if (idx == '1) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vbs_min_slot.sv
module vbs_min_slot #(
    parameter int SAD_W = 16,
    parameter int MV_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic [SAD_W-1:0] cand_sad,
    input  logic [MV_W-1:0]  cand_mv,
    output logic [SAD_W-1:0] best_sad,
    output logic [MV_W-1:0]  best_mv
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best_sad <= '1;
            best_mv  <= '0;
        end else if (upd && (cand_sad < best_sad)) begin
            best_sad <= cand_sad;
            best_mv  <= cand_mv;
        end
    end
endmodule

// File: rtl/vbs_sad_merger.sv
module vbs_sad_merger
    import vbs_pkg::*;
#(
    parameter int SAD4_W   = SAD4_W_DEF,
    parameter int SEARCH_R = SRANGE_DEF
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      start,
    input  logic                                      valid,
    input  logic [NUM_BLK*SAD4_W-1:0]                 sad4,
    output logic                                      done,
    output logic [NUM_SLOT*(SAD4_W+4)-1:0]            min_sad,
    output logic [NUM_SLOT*2*$clog2(2*SEARCH_R)-1:0]  min_mv
);
    localparam int SAD_W = SAD4_W + 4;
    localparam int MVC_W = $clog2(2 * SEARCH_R);
    localparam int MV_W  = 2 * MVC_W;

    typedef struct packed {
        logic [SAD_W-1:0] cost;
        logic [MV_W-1:0]  vec;
    } slot_t;

    logic [15:0][SAD_W-1:0] blk;
    logic [7:0][SAD_W-1:0]  s4x8, s8x4;
    logic [3:0][SAD_W-1:0]  s8x8;
    logic [1:0][SAD_W-1:0]  s8x16, s16x8;
    logic [SAD_W-1:0]       s16x16;
    logic [NUM_SLOT-1:0][SAD_W-1:0] cand;
    slot_t [NUM_SLOT-1:0]   best;
    logic                   accept, run;
    logic [MV_W-1:0]        cand_mv;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_ext
        assign blk[b] = SAD_W'(sad4[b*SAD4_W +: SAD4_W]);
    end

    vbs_vert_tree #(.SAD_W(SAD_W)) u_vert (
        .blk(blk), .s4x8(s4x8), .s8x8(s8x8), .s8x16(s8x16), .s16x16(s16x16)
    );

    vbs_horz_tree #(.SAD_W(SAD_W)) u_horz (
        .blk(blk), .s8x8(s8x8), .s8x4(s8x4), .s16x8(s16x8)
    );

    vbs_cand_ctr #(.SEARCH_R(SEARCH_R), .MVC_W(MVC_W)) u_ctr (
        .clk(clk), .rst(rst), .start(start), .valid(valid),
        .accept(accept), .busy(run), .done(done), .cand_mv(cand_mv)
    );

    // gather every shape's cost into slot order
    for (genvar i = 0; i < 16; i++) begin : g_c4
        assign cand[i] = blk[i];
    end
    for (genvar i = 0; i < 8; i++) begin : g_c8
        assign cand[BASE_4X8+i] = s4x8[i];
        assign cand[BASE_8X4+i] = s8x4[i];
    end
    for (genvar i = 0; i < 4; i++) begin : g_c88
        assign cand[BASE_8X8+i] = s8x8[i];
    end
    for (genvar i = 0; i < 2; i++) begin : g_c16
        assign cand[BASE_8X16+i] = s8x16[i];
        assign cand[BASE_16X8+i] = s16x8[i];
    end
    assign cand[BASE_16X16] = s16x16;

    for (genvar n = 0; n < NUM_SLOT; n++) begin : g_slot
        vbs_min_slot #(.SAD_W(SAD_W), .MV_W(MV_W)) u_slot (
            .clk(clk), .rst(rst), .clr(start), .upd(accept),
            .cand_sad(cand[n]), .cand_mv(cand_mv),
            .best_sad(best[n].cost), .best_mv(best[n].vec)
        );
        assign min_sad[n*SAD_W +: SAD_W] = best[n].cost;
        assign min_mv[n*MV_W +: MV_W]    = best[n].vec;
    end
endmodule

// File: rtl/vbs_sad_merger_chk.sv
module vbs_sad_merger_chk
    import vbs_pkg::*;
#(
    parameter int SAD4_W   = SAD4_W_DEF,
    parameter int SEARCH_R = SRANGE_DEF
) (
    input logic                                     clk,
    input logic                                     rst,
    input logic                                     start,
    input logic                                     valid,
    input logic                                     run,
    input logic                                     done,
    input logic [NUM_SLOT*(SAD4_W+4)-1:0]           min_sad,
    input logic [NUM_SLOT*2*$clog2(2*SEARCH_R)-1:0] min_mv
);
    localparam int SAD_W = SAD4_W + 4;

    logic [SAD_W+1:0] quad_sum;
    always_comb begin
        quad_sum = '0;
        for (int q = 0; q < 4; q++)
            quad_sum = quad_sum + (SAD_W+2)'(min_sad[(BASE_8X8+q)*SAD_W +: SAD_W]);
    end

    // R2: start clears every slot
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (min_sad == '1) && (min_mv == '0));

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: idle valid leaves slots unchanged
    a_r8_idle_ignored: assert property (@(posedge clk) disable iff (rst)
        (valid && !run && !start) |=> ($stable(min_sad) && $stable(min_mv)));

    // R5: whole-block minimum never below the sum of the four quadrant minima
    a_r5_tree_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (quad_sum <= (SAD_W+2)'(min_sad[BASE_16X16*SAD_W +: SAD_W])));

    // R6: without start a slot cost never rises
    for (genvar n = 0; n < NUM_SLOT; n++) begin : g_mono
        a_r6_never_rises: assert property (@(posedge clk) disable iff (rst)
            !start |=> (min_sad[n*SAD_W +: SAD_W] <= $past(min_sad[n*SAD_W +: SAD_W])));
    end
endmodule

bind vbs_sad_merger vbs_sad_merger_chk #(.SAD4_W(SAD4_W), .SEARCH_R(SEARCH_R)) u_chk (
    .clk(clk), .rst(rst), .start(start), .valid(valid), .run(run),
    .done(done), .min_sad(min_sad), .min_mv(min_mv)
);

// File: tb/tb_vbs_sad_merger.sv
module tb_vbs_sad_merger;
    localparam int NS = 41;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         valid = 1'b0;
    logic [191:0] sad4 = '0;
    logic         done;
    logic [NS*16-1:0] min_sad;
    logic [NS*8-1:0]  min_mv;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // behavioural model state
    int          m_sad [NS];
    logic [7:0]  m_mv  [NS];
    bit          m_run, m_done;
    int          m_cnt;

    always #10 clk = ~clk;

    vbs_sad_merger dut (
        .clk(clk), .rst(rst), .start(start), .valid(valid), .sad4(sad4),
        .done(done), .min_sad(min_sad), .min_mv(min_mv)
    );

    function automatic int blk_val(int r, int c);
        return int'(sad4[(r*4+c)*12 +: 12]);
    endfunction

    // shape geometry in 4x4 units: x, y, width, height
    function automatic int shape_cost(int p);
        int x, y, w, h, k, s;
        if (p < 16)      begin x = p % 4; y = p / 4; w = 1; h = 1; end
        else if (p < 24) begin k = p - 16; x = k % 4; y = (k / 4) * 2; w = 1; h = 2; end
        else if (p < 32) begin k = p - 24; x = (k % 2) * 2; y = k / 2; w = 2; h = 1; end
        else if (p < 36) begin k = p - 32; x = (k % 2) * 2; y = (k / 2) * 2; w = 2; h = 2; end
        else if (p < 38) begin k = p - 36; x = k * 2; y = 0; w = 2; h = 4; end
        else if (p < 40) begin k = p - 38; x = 0; y = k * 2; w = 4; h = 2; end
        else             begin x = 0; y = 0; w = 4; h = 4; end
        s = 0;
        for (int r = y; r < y + h; r++)
            for (int c = x; c < x + w; c++)
                s += blk_val(r, c);
        return s;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < NS; i++) begin m_sad[i] = 65535; m_mv[i] = 8'h00; end
            m_run = 0; m_done = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (start) begin
                for (int i = 0; i < NS; i++) begin m_sad[i] = 65535; m_mv[i] = 8'h00; end
                m_run = 1; m_cnt = 0;
            end else if (valid && m_run) begin
                logic [3:0] dx, dy;
                dx = 4'(m_cnt % 16 - 8);
                dy = 4'(m_cnt / 16 - 8);
                for (int i = 0; i < NS; i++) begin
                    int c;
                    c = shape_cost(i);
                    if (c < m_sad[i]) begin m_sad[i] = c; m_mv[i] = {dy, dx}; end
                end
                if (m_cnt == 255) begin m_run = 0; m_done = 1; end
                m_cnt++;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cyc > 0) begin
            bit bad;
            bad = 0;
            n_chk++;
            if (done !== m_done) begin
                bad = 1;
                $display("FAIL R7 done actual=%0b expected=%0b", done, m_done);
            end
            for (int i = 0; i < NS; i++) begin
                if (!bad && int'(min_sad[i*16 +: 16]) != m_sad[i]) begin
                    bad = 1;
                    $display("FAIL %s slot %0d cost actual=%0d expected=%0d",
                             (i < 32) ? "R4" : "R5", i, min_sad[i*16 +: 16], m_sad[i]);
                end
                if (!bad && min_mv[i*8 +: 8] !== m_mv[i]) begin
                    bad = 1;
                    $display("FAIL R3 slot %0d vector actual=%h expected=%h",
                             i, min_mv[i*8 +: 8], m_mv[i]);
                end
            end
            if (bad) n_fail++;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // mode 0 random, 1 constant, 2 all maximum, 3 descending
    task automatic sweep(int mode);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (mode == 0 && ($urandom % 5) == 0) begin
                valid = 1'b0;
                @(negedge clk);
            end
            valid = 1'b1;
            for (int b = 0; b < 16; b++) begin
                case (mode)
                    0: sad4[b*12 +: 12] = 12'($urandom % 4096);
                    1: sad4[b*12 +: 12] = 12'd100;
                    2: sad4[b*12 +: 12] = 12'hFFF;
                    default: sad4[b*12 +: 12] = 12'(300 - k);
                endcase
            end
        end
        @(negedge clk);
        check("R7 done after last candidate", int'(done), 1);
        valid = 1'b0;
        @(negedge clk);
        check("R7 done falls", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cost slot 40", int'(min_sad[40*16 +: 16]), 65535);
        check("R1 reset vector slot 0", int'(min_mv[7:0]), 0);
        check("R1 reset done", int'(done), 0);
        rst = 1'b0;

        pulse_start();
        sweep(0);

        // valid after the search ends must be ignored
        @(negedge clk);
        begin
            int keep0, keep40;
            keep0 = int'(min_sad[15:0]);
            keep40 = int'(min_sad[40*16 +: 16]);
            valid = 1'b1; sad4 = '0;
            repeat (3) @(negedge clk);
            valid = 1'b0;
            check("R8 idle valid slot 0", int'(min_sad[15:0]), keep0);
            check("R8 idle valid slot 40", int'(min_sad[40*16 +: 16]), keep40);
        end

        // start together with valid: clears, valid not counted
        @(negedge clk);
        start = 1'b1; valid = 1'b1; sad4 = '0;
        @(negedge clk);
        start = 1'b0; valid = 1'b0;
        check("R2 start clears slot 0", int'(min_sad[15:0]), 65535);
        check("R2 start clears vector 40", int'(min_mv[40*8 +: 8]), 0);
        sweep(0);

        pulse_start();
        sweep(1);
        check("R6 tie keeps first slot 40", int'(min_mv[40*8 +: 8]), 8'h88);
        check("R6 tie keeps first slot 17", int'(min_mv[17*8 +: 8]), 8'h88);

        pulse_start();
        sweep(2);
        check("R9 full sum slot 40", int'(min_sad[40*16 +: 16]), 65520);
        check("R9 8x8 sum slot 32", int'(min_sad[32*16 +: 16]), 16380);

        pulse_start();
        sweep(3);
        check("R3 last candidate vector slot 40", int'(min_mv[40*8 +: 8]), 8'h77);
        check("R3 last candidate cost slot 5", int'(min_sad[5*16 +: 16]), 45);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule